// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces operand addresses for indirect memory access. It keeps a bank of index pointers. Each pointer has its own length register, and the bank also holds a set of modify registers. When an access is strobed, the block presents the current value of the chosen pointer as the address. It then post-modifies that pointer by the chosen modify value, using a signed step. If the pointer's length is nonzero, the step stays inside a circular buffer whose base is the pointer with its low bits cleared. A per-access flag mirrors the output address bit for bit, for FFT-style reordering, and leaves the stored pointer untouched by the mirroring.

Software loads and inspects the registers through a plain write port and a combinational read port. Accesses use a single-cycle strobe with no back-pressure. The generator always accepts a strobe, and the address comes out, marked valid, exactly one clock after the strobe. The valid flag is a marker for that cycle only. There is no ready signal, and a consumer must take the address in that cycle.

Top module: `addr_gen_circ`

## Requirements
- R1: After reset every pointer, modify and length register reads back 0 and `addr_vld` is low.
- R2: A write with `wr_en` high stores `wr_data` into the register picked by `wr_cls` (0 = pointer, 1 = modify, 2 = length) and `wr_idx`. `rd_data` shows that register once the clock edge has passed. Class 3 always reads 0.
- R3: A cycle with `acc_en` high drives `addr_vld` high in the next cycle, together with the pointer value from before the access. A cycle without `acc_en` drives `addr_vld` low in the next cycle.
- R4: When the pointer's length is 0, the pointer becomes pointer + modify, taken modulo 2^14.
- R5: When the length L is nonzero, the buffer base is the pointer with its low ceil(log2 L) bits cleared. If pointer + modify reaches base + L or beyond, L is subtracted.
- R6: When L is nonzero and pointer + modify falls below the base, L is added.
- R7: Any pointer may be paired with any modify register. Modify values are 14-bit two's complement.
- R8: With `acc_brev` high, `addr_out` is the old pointer with bit 13 swapped with bit 0, bit 12 with bit 1, and so on. The stored pointer updates exactly as it would without the flag.
- R9: A pointer write and an access to that same pointer in the same cycle: the written value is stored, and the address output still carries the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_cls | input | 2 | Write register class (0 ptr, 1 mod, 2 len) |
| wr_idx | input | 2 | Write register index |
| wr_data | input | 14 | Write data |
| rd_cls | input | 2 | Read register class |
| rd_idx | input | 2 | Read register index |
| rd_data | output | 14 | Read data (combinational) |
| acc_en | input | 1 | Access strobe |
| acc_ptr | input | 2 | Pointer select for the access |
| acc_mod | input | 2 | Modify register select for the access |
| acc_brev | input | 1 | Mirror the output address |
| addr_out | output | 14 | Generated address |
| addr_vld | output | 1 | Address valid, one cycle after the strobe |

## Verification
The bench uses the default parameters: a 14-bit address and four registers of each class. At that size it can drive a linear step across the top of the address space and a signed backward step. It also places short non-power-of-two buffers, lengths 6 and 5, so that both wrap directions are hit within a few accesses. A behavioural model built from integer arrays predicts the address and a register readback on every clock. This covers mirrored addresses on full-width 14-bit values and a pointer write colliding with an access to the same pointer.

// File: rtl/dagen_pkg.sv
package dagen_pkg;
  typedef enum logic [1:0] {
    RC_PTR  = 2'd0,
    RC_MOD  = 2'd1,
    RC_LEN  = 2'd2,
    RC_NONE = 2'd3
  } reg_class_e;
endpackage

// File: rtl/dagen_regs.sv
module dagen_regs
  import dagen_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_class_e    wr_cls,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  reg_class_e    rd_cls,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  input  logic [IW-1:0] sel_ptr,
  input  logic [IW-1:0] sel_mod,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] mod_o,
  output logic [AW-1:0] len_o,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val
);
  logic [AW-1:0] ptr_q [NREG];
  logic [AW-1:0] mod_q [NREG];
  logic [AW-1:0] len_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n) begin
        ptr_q[i] <= '0;
        mod_q[i] <= '0;
        len_q[i] <= '0;
      end else begin
        if (wr_en && wr_cls == RC_PTR && wr_idx == IW'(i))
          ptr_q[i] <= wr_data;
        else if (upd_en && sel_ptr == IW'(i))
          ptr_q[i] <= upd_val;
        if (wr_en && wr_cls == RC_MOD && wr_idx == IW'(i))
          mod_q[i] <= wr_data;
        if (wr_en && wr_cls == RC_LEN && wr_idx == IW'(i))
          len_q[i] <= wr_data;
      end
    end
  end

  assign ptr_o = ptr_q[sel_ptr];
  assign len_o = len_q[sel_ptr];
  assign mod_o = mod_q[sel_mod];

  always_comb begin
    unique case (rd_cls)
      RC_PTR:  rd_data = ptr_q[rd_idx];
      RC_MOD:  rd_data = mod_q[rd_idx];
      RC_LEN:  rd_data = len_q[rd_idx];
      default: rd_data = '0;
    endcase
  end

  // R9: a register write takes precedence over the post-modify update
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cls == RC_PTR) |=> ptr_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/dagen_step.sv
module dagen_step #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] next_o
);
  localparam int EW = AW + 2;

  logic [AW-1:0]        span_mask;
  logic [AW-1:0]        base;
  logic signed [EW-1:0] sum;
  logic signed [EW-1:0] base_x;
  logic signed [EW-1:0] lim_x;
  logic signed [EW-1:0] len_x;

  always_comb begin
    span_mask = len_i - AW'(1);
    for (int s = 1; s < AW; s = s * 2)
      span_mask = span_mask | (span_mask >> s);
  end

  assign base   = ptr_i & ~span_mask;
  assign len_x  = signed'({2'b00, len_i});
  assign base_x = signed'({2'b00, base});
  assign lim_x  = base_x + len_x;
  assign sum    = signed'({2'b00, ptr_i}) + signed'({{2{mod_i[AW-1]}}, mod_i});

  always_comb begin
    if (len_i == '0)
      next_o = sum[AW-1:0];
    else if (sum >= lim_x)
      next_o = AW'(sum - len_x);
    else if (sum < base_x)
      next_o = AW'(sum + len_x);
    else
      next_o = sum[AW-1:0];
  end
endmodule

// File: rtl/dagen_brev.sv
module dagen_brev #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] in_i,
  output logic [AW-1:0] out_o
);
  for (genvar b = 0; b < AW; b++) begin : g_mirror
    assign out_o[b] = in_i[AW-1-b];
  end
endmodule

// File: rtl/addr_gen_circ.sv
module addr_gen_circ
  import dagen_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_cls,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_cls,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  input  logic          acc_en,
  input  logic [IW-1:0] acc_ptr,
  input  logic [IW-1:0] acc_mod,
  input  logic          acc_brev,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  logic [AW-1:0] ptr_sel, mod_sel, len_sel, ptr_next, ptr_mir;

  dagen_regs #(.AW(AW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_cls(reg_class_e'(wr_cls)), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_cls(reg_class_e'(rd_cls)), .rd_idx(rd_idx), .rd_data(rd_data),
    .sel_ptr(acc_ptr), .sel_mod(acc_mod),
    .ptr_o(ptr_sel), .mod_o(mod_sel), .len_o(len_sel),
    .upd_en(acc_en), .upd_val(ptr_next)
  );

  dagen_step #(.AW(AW)) u_step (
    .ptr_i(ptr_sel), .mod_i(mod_sel), .len_i(len_sel), .next_o(ptr_next)
  );

  dagen_brev #(.AW(AW)) u_brev (
    .in_i(ptr_sel), .out_o(ptr_mir)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= acc_en;
      if (acc_en) addr_out <= acc_brev ? ptr_mir : ptr_sel;
    end
  end

  // R3: valid follows the strobe by one cycle
  a_r3_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> addr_vld);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !addr_vld);
  a_r3_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_brev) |=> addr_out == $past(ptr_sel));
  // R8: mirroring preserves the set bits of the pointer
  a_r8_mirror_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_brev) |=> $countones(addr_out) == $countones($past(ptr_sel)));
endmodule

// File: tb/addr_gen_circ_bench.sv
module addr_gen_circ_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_cls = '0, rd_cls = '0;
  logic [1:0]  wr_idx = '0, rd_idx = '0, acc_ptr = '0, acc_mod = '0;
  logic [13:0] wr_data = '0;
  logic        acc_en = 1'b0, acc_brev = 1'b0;
  logic [13:0] rd_data, addr_out;
  logic        addr_vld;

  int errors = 0, checks = 0;
  int mp [4], mm [4], ml [4];

  always #2.5 clk = ~clk;

  addr_gen_circ u_addr_gen_circ (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rev14(int v);
    int r = 0;
    for (int b = 0; b < 14; b++) if (v[b]) r |= 1 << (13 - b);
    return r;
  endfunction

  function automatic int step(int p, int m, int l);
    int ms = (m >= 8192) ? m - 16384 : m;
    int pw = 1, base, s;
    if (l == 0) return (p + ms) & 16'h3FFF;
    while (pw < l) pw = pw * 2;
    base = p - (p % pw);
    s = p + ms;
    if (s >= base + l) s = s - l;
    else if (s < base) s = s + l;
    return s & 16'h3FFF;
  endfunction

  function automatic int model_rd(int c, int i);
    case (c)
      0: return mp[i];
      1: return mm[i];
      2: return ml[i];
      default: return 0;
    endcase
  endfunction

  task automatic cyc(string req, bit we, int wc, int wi, int wd,
                     bit ae, int ap, int am, bit ab, int rc, int ri);
    int exp_addr, np;
    @(negedge clk);
    wr_en = we; wr_cls = 2'(wc); wr_idx = 2'(wi); wr_data = 14'(wd);
    acc_en = ae; acc_ptr = 2'(ap); acc_mod = 2'(am); acc_brev = ab;
    rd_cls = 2'(rc); rd_idx = 2'(ri);
    exp_addr = ab ? rev14(mp[ap]) : mp[ap];
    np = step(mp[ap], mm[am], ml[ap]);
    if (ae) mp[ap] = np;
    if (we) begin
      if (wc == 0) mp[wi] = wd;
      else if (wc == 1) mm[wi] = wd;
      else if (wc == 2) ml[wi] = wd;
    end
    @(posedge clk); #1;
    chk({req, " vld"}, int'(addr_vld), int'(ae));
    if (ae) chk({req, " addr"}, int'(addr_out), exp_addr);
    chk({req, " rd"}, int'(rd_data), model_rd(rc, ri));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mp[i] = 0; mm[i] = 0; ml[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 4; i++) cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, c, i);
    // R2: writes and readback, class 3 reads zero
    cyc("R2", 1, 0, 0, 100, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 1, 0, 5, 0, 0, 0, 0, 1, 0);
    cyc("R2", 1, 2, 3, 9, 0, 0, 0, 0, 2, 3);
    cyc("R2", 1, 2, 3, 0, 0, 0, 0, 0, 3, 3);
    // R4 and R3: linear stepping, idle cycle quiet
    cyc("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 16380, 0, 0, 0, 0, 0, 0);
    cyc("R4", 1, 1, 2, 10, 0, 0, 0, 0, 1, 2);
    cyc("R4", 0, 0, 0, 0, 1, 0, 2, 0, 0, 0);
    // R5: forward wrap, L=6 at base 0x20
    cyc("R5", 1, 0, 1, 32, 0, 0, 0, 0, 0, 1);
    cyc("R5", 1, 2, 1, 6, 0, 0, 0, 0, 2, 1);
    cyc("R5", 1, 1, 1, 4, 0, 0, 0, 0, 1, 1);
    for (int k = 0; k < 5; k++) cyc("R5", 0, 0, 0, 0, 1, 1, 1, 0, 0, 1);
    // R6 and R7: backward step of -3 on pointer 2 with L=5, base 0x40
    cyc("R6", 1, 0, 2, 65, 0, 0, 0, 0, 0, 2);
    cyc("R6", 1, 2, 2, 5, 0, 0, 0, 0, 2, 2);
    cyc("R7", 1, 1, 3, 16381, 0, 0, 0, 0, 1, 3);
    for (int k = 0; k < 5; k++) cyc("R6", 0, 0, 0, 0, 1, 2, 3, 0, 0, 2);
    // R7: mixed pointer/modify pairs
    cyc("R7", 0, 0, 0, 0, 1, 3, 0, 0, 0, 3);
    cyc("R7", 0, 0, 0, 0, 1, 1, 3, 0, 0, 1);
    cyc("R7", 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    // R8: mirrored output, pointer still advances
    cyc("R8", 1, 0, 3, 14'h0A5F, 0, 0, 0, 0, 0, 3);
    cyc("R8", 0, 0, 0, 0, 1, 3, 0, 1, 0, 3);
    cyc("R8", 0, 0, 0, 0, 1, 3, 0, 1, 0, 3);
    cyc("R8", 0, 0, 0, 0, 1, 1, 1, 1, 0, 1);
    // R9: write and access to the same pointer in one cycle
    cyc("R9", 1, 0, 3, 777, 1, 3, 0, 0, 0, 3);
    cyc("R9", 0, 0, 0, 0, 1, 3, 0, 0, 0, 3);
    cyc("R9", 1, 0, 1, 40, 1, 1, 1, 1, 0, 1);
    cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule